// File: doc/BRIEF.md
# Peripheral Controller Host Port

This block is the host side of a programmable peripheral controller. A master processor reaches it through chip select, active-low read and write strobes, a select line that picks data or status, and a byte-wide data bus. The internal CPU of the controller reaches the same storage through single-cycle buffer read and buffer write commands. Two flags show who holds a pending byte: the input flag says the host has written a byte the CPU has not yet taken, and the output flag says the CPU has written a byte the host has not yet read.

The host polls a 4-bit status word to see both flags together with two CPU-owned flags. Host reads raise no interrupt. Host writes can raise a one-cycle interrupt request toward the CPU once the CPU has enabled it. Every host access is counted once, on the first clock cycle in which chip select and the strobe are both low. The strobe may stay low for as many cycles as the host likes.

Top module: `hsi_host_port`

## Requirements
- R1: After reset the input flag, output flag, interrupt enable and interrupt request are 0, and both byte buffers hold 0.
- R2: A host write starts in the first cycle with cs_n=0 and wr_n=0 after a cycle in which that was not true. At that clock edge the byte on host_din is stored in the input buffer and the input flag (ibf) is set. Holding the strobe low for more cycles counts as one write.
- R3: While cpu_rd is high, cpu_rd_data shows the input buffer. At the edge ibf clears, unless a host write starts in the same cycle; in that case ibf stays 1 and the new byte is stored.
- R4: A host write that starts while ibf is 1 overwrites the input buffer and leaves ibf at 1.
- R5: A CPU write (cpu_wr high) stores cpu_wr_data in the output buffer and sets the output flag (obf) at that edge.
- R6: A host data read (sel=0) drives the output buffer on host_dout while cs_n=0 and rd_n=0. At the edge where it starts, obf clears, unless cpu_wr is high in that cycle; in that case obf stays 1 and the new byte is stored.
- R7: A host status read (sel=1) drives host_dout = {4'b0, f1, f0, ibf, obf}, with obf in bit 0, ibf in bit 1, f0 in bit 2 and f1 in bit 3. It changes no flag.
- R8: When the interrupt is enabled, each host write start sets irq high for exactly the one cycle after that edge. irq stays 0 when the interrupt is disabled, and host reads never raise it.
- R9: int_on sets the interrupt enable and int_off clears it. If both are high in the same cycle, the enable ends cleared.
- R10: host_oe is 1 exactly while cs_n=0 and rd_n=0. host_dout is 0 whenever host_oe is 0.
- R11: Strobes seen while cs_n=1 change no flag and no buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Host chip select, active low |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| sel | input | 1 | 0 selects data, 1 selects status |
| host_din | input | 8 | Host write data |
| host_dout | output | 8 | Host read data |
| host_oe | output | 1 | Host bus drive enable |
| cpu_rd | input | 1 | CPU takes the input buffer |
| cpu_rd_data | output | 8 | Input buffer contents |
| cpu_wr | input | 1 | CPU loads the output buffer |
| cpu_wr_data | input | 8 | Byte for the output buffer |
| f0 | input | 1 | CPU-owned flag 0 |
| f1 | input | 1 | CPU-owned flag 1 |
| int_on | input | 1 | Enable the write interrupt |
| int_off | input | 1 | Disable the write interrupt |
| ibf | output | 1 | Input buffer full (CPU test) |
| obf | output | 1 | Output buffer full (CPU test) |
| irq | output | 1 | Write interrupt request pulse |

## Verification
A wrong flag shows at once on the ibf and obf test outputs, and the host sees it in the status word on its next poll. A lost or doubled edge detection shows up in the cycle after the strobe falls. It appears as a second irq pulse while the strobe is held low, or as ibf coming back after the CPU has cleared it. A wrong buffer shows up on cpu_rd_data or host_dout during the very access that reads it, so each error is visible within one clock of its cause.

// File: rtl/hsi_pkg.sv
package hsi_pkg;
    localparam int STAT_W    = 4;
    localparam int ST_OBF    = 0;
    localparam int ST_IBF    = 1;
    localparam int ST_F0     = 2;
    localparam int ST_F1     = 3;

    typedef struct packed {
        logic ibf;
        logic obf;
        logic irq_en;
        logic irq;
    } hsi_flags_t;

    localparam hsi_flags_t FLAGS_RST = '{ibf: 1'b0, obf: 1'b0, irq_en: 1'b0, irq: 1'b0};
endpackage

// File: rtl/hsi_access_detect.sv
module hsi_access_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic start
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = active;
        start  = active & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/hsi_read_mux.sv
module hsi_read_mux #(
    parameter int DW = 8
) (
    input  logic          rd_active,
    input  logic          sel,
    input  logic [DW-1:0] data_byte,
    input  logic [DW-1:0] status_byte,
    output logic [DW-1:0] dout,
    output logic          oe
);
    always_comb begin
        oe   = rd_active;
        dout = '0;
        if (rd_active) dout = sel ? status_byte : data_byte;
    end
endmodule

// File: rtl/hsi_host_port.sv
module hsi_host_port
    import hsi_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic          sel,
    input  logic [DW-1:0] host_din,
    output logic [DW-1:0] host_dout,
    output logic          host_oe,
    input  logic          cpu_rd,
    output logic [DW-1:0] cpu_rd_data,
    input  logic          cpu_wr,
    input  logic [DW-1:0] cpu_wr_data,
    input  logic          f0,
    input  logic          f1,
    input  logic          int_on,
    input  logic          int_off,
    output logic          ibf,
    output logic          obf,
    output logic          irq
);
    localparam int PAD_W = DW - STAT_W;

    hsi_flags_t    flg_d, flg_q;
    logic [DW-1:0] inb_d, inb_q;
    logic [DW-1:0] outb_d, outb_q;

    logic wr_active, rd_active, rd_data_active;
    logic wr_start, rd_data_start;
    logic [STAT_W-1:0] stat_bits;
    logic [DW-1:0]     status_byte;

    assign wr_active      = ~cs_n & ~wr_n;
    assign rd_active      = ~cs_n & ~rd_n;
    assign rd_data_active = rd_active & ~sel;

    hsi_access_detect u_wr_det (
        .clk(clk), .rst_n(rst_n), .active(wr_active), .start(wr_start)
    );

    hsi_access_detect u_rd_det (
        .clk(clk), .rst_n(rst_n), .active(rd_data_active), .start(rd_data_start)
    );

    always_comb begin
        stat_bits         = '0;
        stat_bits[ST_OBF] = flg_q.obf;
        stat_bits[ST_IBF] = flg_q.ibf;
        stat_bits[ST_F0]  = f0;
        stat_bits[ST_F1]  = f1;
        status_byte       = {{PAD_W{1'b0}}, stat_bits};
    end

    hsi_read_mux #(.DW(DW)) u_mux (
        .rd_active  (rd_active),
        .sel        (sel),
        .data_byte  (outb_q),
        .status_byte(status_byte),
        .dout       (host_dout),
        .oe         (host_oe)
    );

    always_comb begin
        flg_d  = flg_q;
        inb_d  = inb_q;
        outb_d = outb_q;

        // input direction: host write set wins over CPU take
        if (cpu_rd)   flg_d.ibf = 1'b0;
        if (wr_start) begin
            flg_d.ibf = 1'b1;
            inb_d     = host_din;
        end

        // output direction: CPU load wins over host take
        if (rd_data_start) flg_d.obf = 1'b0;
        if (cpu_wr) begin
            flg_d.obf = 1'b1;
            outb_d    = cpu_wr_data;
        end

        if (int_on)  flg_d.irq_en = 1'b1;
        if (int_off) flg_d.irq_en = 1'b0;

        flg_d.irq = wr_start & flg_q.irq_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flg_q  <= FLAGS_RST;
            inb_q  <= '0;
            outb_q <= '0;
        end else begin
            flg_q  <= flg_d;
            inb_q  <= inb_d;
            outb_q <= outb_d;
        end
    end

    assign cpu_rd_data = inb_q;
    assign ibf         = flg_q.ibf;
    assign obf         = flg_q.obf;
    assign irq         = flg_q.irq;
endmodule

// File: rtl/hsi_checker.sv
module hsi_checker (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic rd_n,
    input logic wr_n,
    input logic sel,
    input logic cpu_rd,
    input logic cpu_wr,
    input logic ibf,
    input logic obf,
    input logic irq
);
    logic wr_prev_q, rdd_prev_q;
    logic wr_now, rdd_now, wr_go, rdd_go, st_rd;

    assign wr_now  = !cs_n && !wr_n;
    assign rdd_now = !cs_n && !rd_n && !sel;
    assign st_rd   = !cs_n && !rd_n && sel;
    assign wr_go   = wr_now && !wr_prev_q;
    assign rdd_go  = rdd_now && !rdd_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_prev_q  <= 1'b0;
            rdd_prev_q <= 1'b0;
        end else begin
            wr_prev_q  <= wr_now;
            rdd_prev_q <= rdd_now;
        end
    end

    a_r2_write_sets_ibf: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |=> ibf);
    a_r3_cpu_take_clears_ibf: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !wr_go) |=> !ibf);
    a_r5_cpu_load_sets_obf: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr |=> obf);
    a_r6_host_take_clears_obf: assert property (@(posedge clk) disable iff (!rst_n)
        (rdd_go && !cpu_wr) |=> !obf);
    a_r7_status_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st_rd && !wr_go && !cpu_rd && !cpu_wr) |=> ($stable(ibf) && $stable(obf)));
    a_r8_irq_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(wr_go));
    a_r8_irq_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_go) |=> !irq);
endmodule

bind hsi_host_port hsi_checker u_hsi_checker (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .sel(sel),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .ibf(ibf), .obf(obf), .irq(irq)
);

// File: tb/hsi_host_port_bench.sv
module hsi_host_port_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, sel = 1'b0;
    logic [7:0] host_din = '0;
    logic [7:0] host_dout;
    logic host_oe;
    logic cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [7:0] cpu_rd_data;
    logic [7:0] cpu_wr_data = '0;
    logic f0 = 1'b0, f1 = 1'b0, int_on = 1'b0, int_off = 1'b0;
    logic ibf, obf, irq;

    int n_run = 0, n_fail = 0;
    logic e_ibf = 0, e_obf = 0, e_en = 0;
    logic [7:0] e_in = 0, e_out = 0;

    always #2 clk = ~clk;

    hsi_host_port u_hsi_host_port (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [7:0] v);
        @(negedge clk); cs_n = 0; wr_n = 0; host_din = v;
        @(negedge clk);
        e_in = v; e_ibf = 1;
        chk("R2 ibf set", ibf, 1);
        chk("R4 input byte", cpu_rd_data, v);
        chk("R8 irq pulse", irq, e_en);
        cs_n = 1; wr_n = 1;
        @(negedge clk);
        chk("R8 irq one cycle", irq, 0);
    endtask

    task automatic cpu_read();
        @(negedge clk); cpu_rd = 1; #1;
        chk("R3 cpu read data", cpu_rd_data, e_in);
        @(negedge clk); cpu_rd = 0; e_ibf = 0;
        chk("R3 ibf cleared", ibf, 0);
    endtask

    task automatic cpu_write(input logic [7:0] v);
        @(negedge clk); cpu_wr = 1; cpu_wr_data = v;
        @(negedge clk); cpu_wr = 0; e_out = v; e_obf = 1;
        chk("R5 obf set", obf, 1);
    endtask

    task automatic host_read_data();
        @(negedge clk); cs_n = 0; rd_n = 0; sel = 0; #1;
        chk("R6 data out", host_dout, e_out);
        chk("R10 oe high", host_oe, 1);
        @(negedge clk); e_obf = 0;
        chk("R6 obf cleared", obf, 0);
        chk("R8 no irq on read", irq, 0);
        cs_n = 1; rd_n = 1; #1;
        chk("R10 oe low", host_oe, 0);
        chk("R10 dout zero", host_dout, 0);
    endtask

    task automatic host_read_status();
        @(negedge clk); cs_n = 0; rd_n = 0; sel = 1; #1;
        chk("R7 status", host_dout, {4'b0, f1, f0, e_ibf, e_obf});
        @(negedge clk);
        chk("R7 ibf kept", ibf, e_ibf);
        chk("R7 obf kept", obf, e_obf);
        cs_n = 1; rd_n = 1; sel = 0;
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ibf", ibf, 0); chk("R1 obf", obf, 0); chk("R1 irq", irq, 0);
        chk("R1 inbuf", cpu_rd_data, 0); chk("R1 oe", host_oe, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 ibf after release", ibf, 0);
        // R1: output buffer reads 0
        @(negedge clk); cs_n = 0; rd_n = 0; sel = 0; #1;
        chk("R1 outbuf", host_dout, 0);
        @(negedge clk); cs_n = 1; rd_n = 1;

        // R2/R3 sweep of host-to-CPU bytes, interrupt disabled
        for (int v = 0; v < 256; v += 17) begin host_write(8'(v)); cpu_read(); end
        // R5/R6 sweep of CPU-to-host bytes
        for (int v = 0; v < 256; v++) begin cpu_write(8'(v)); host_read_data(); end

        // R7 status over every flag combination
        for (int k = 0; k < 16; k++) begin
            f0 = k[0]; f1 = k[1];
            if (k[2]) host_write(8'h5A + 8'(k));
            if (k[3]) cpu_write(8'hC3 ^ 8'(k));
            host_read_status();
            if (k[2]) cpu_read();
            if (k[3]) host_read_data();
        end
        f0 = 0; f1 = 0;

        // R4 overwrite while full
        host_write(8'h11); host_write(8'h22);
        chk("R4 ibf stays", ibf, 1);
        cpu_read();

        // R2 held strobe counts once
        @(negedge clk); cs_n = 0; wr_n = 0; host_din = 8'h3C;
        @(negedge clk); e_in = 8'h3C;
        cpu_rd = 1;
        @(negedge clk); cpu_rd = 0;
        @(negedge clk); @(negedge clk);
        chk("R2 held strobe single", ibf, 0);
        cs_n = 1; wr_n = 1; e_ibf = 0;

        // R3 simultaneous take and host write start
        host_write(8'h40);
        @(negedge clk); cs_n = 0; wr_n = 0; host_din = 8'h41; cpu_rd = 1;
        @(negedge clk); cpu_rd = 0; cs_n = 1; wr_n = 1; e_in = 8'h41;
        chk("R3 write wins ibf", ibf, 1);
        chk("R3 write wins data", cpu_rd_data, 8'h41);
        cpu_read();

        // R6 simultaneous CPU load and host data read
        cpu_write(8'h90);
        @(negedge clk); cs_n = 0; rd_n = 0; sel = 0; cpu_wr = 1; cpu_wr_data = 8'h91; #1;
        chk("R6 old byte driven", host_dout, 8'h90);
        @(negedge clk); cpu_wr = 0; cs_n = 1; rd_n = 1; e_out = 8'h91;
        chk("R6 load wins obf", obf, 1);
        host_read_data();

        // R11 strobes without chip select
        @(negedge clk); wr_n = 0; rd_n = 0; host_din = 8'hEE; #1;
        chk("R11 oe off", host_oe, 0);
        @(negedge clk); @(negedge clk); wr_n = 1; rd_n = 1;
        chk("R11 ibf unchanged", ibf, 0);
        chk("R11 inbuf unchanged", cpu_rd_data, e_in);

        // R9/R8 interrupt enable
        @(negedge clk); int_on = 1; @(negedge clk); int_on = 0; e_en = 1;
        for (int v = 1; v < 256; v += 51) begin host_write(8'(v)); cpu_read(); end
        cpu_write(8'h77); host_read_data();
        @(negedge clk); int_on = 1; int_off = 1; @(negedge clk); int_on = 0; int_off = 0; e_en = 0;
        host_write(8'h66);
        chk("R9 off wins", irq, 0);
        cpu_read();
        // R8 held write with interrupt on gives one pulse
        @(negedge clk); int_on = 1; @(negedge clk); int_on = 0;
        @(negedge clk); cs_n = 0; wr_n = 0; host_din = 8'h12;
        @(negedge clk); chk("R8 pulse on held write", irq, 1);
        @(negedge clk); chk("R8 no second pulse", irq, 0);
        @(negedge clk); cs_n = 1; wr_n = 1;

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule